// File: doc/BRIEF.md
# ROM Region Checksum Generator

This block walks a byte region of a configuration memory and folds every byte into a 32-bit running sum. Each step rotates the old sum left by one bit and then adds the new byte, modulo 2^32. A four-byte field near the end of the region holds the checksum itself. While summing, the block reads those four bytes as zero, whatever they currently hold. When the pass is over, it writes the final sum into that field, so the stored image carries its own check value.

A controller loads the memory image, presents a base offset and a length, and pulses `start`. The block reads one byte per cycle through a synchronous port with one cycle of read latency. It then writes the four checksum bytes, most significant byte first, and pulses `done`. For a 4096-byte image whose first 8 bytes (a 6-byte station address and two zero bytes) are left out, the base is 8 and the length is 4088. A length too short to hold the field is refused: the block raises `err` and makes no memory access.

Top module: `cksum_rom_gen`

## Requirements
- R1: A `start` seen while idle latches `base_in` and `len_in`. The block then asserts `rd_en` for exactly `len` consecutive cycles, with `rd_addr` equal to base, base+1, …, base+len-1. `rd_data` is taken one cycle after the address.
- R2: The sum is cleared to zero when `start` is taken. For each region byte, in address order, the new sum is {old[30:0], old[31]} + byte, modulo 2^32.
- R3: The bytes at region offsets len-12, len-11, len-10 and len-9 count as zero in the sum, whatever the memory holds there.
- R4: After the pass, exactly four write cycles follow, at ascending addresses: offset len-12 receives sum[31:24], len-11 receives sum[23:16], len-10 receives sum[15:8] and len-9 receives sum[7:0]. No other address is written.
- R5: `done` is high for exactly one cycle. It rises len+5 clock edges after the edge that takes `start`, which is the cycle after the last write. `sum_out` holds the final sum from the end of the pass until the next `start` is taken.
- R6: `start` has no effect while `busy` is high. The running job's addresses, sum and timing are unchanged by it.
- R7: A length below 12 is refused. No reads or writes occur, `done` pulses in the cycle right after the start edge, `sum_out` reads 0, and `err` stays high until the next `start` is taken. An accepted start clears `err`.
- R8: Read and write addresses wrap modulo 2^ADDR_W.
- R9: After reset, `busy`, `done`, `err`, `rd_en` and `wr_en` are low and `sum_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Job request, taken only while idle |
| base_in | input | ADDR_W | First byte address of the region |
| len_in | input | ADDR_W+1 | Region length in bytes |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | 8 | Read data, valid one cycle after the strobe |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | 8 | Memory write byte |
| busy | output | 1 | A job is in progress (through the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was refused for a short length |
| sum_out | output | 32 | Final checksum |

## Verification
Most wrong internal states surface first as a wrong read address within one cycle of starting. Otherwise they show as a wrong sum or a wrong write-back byte, about len+5 cycles after the start. An error in the pipeline valid flag or in the field mask changes `sum_out` and all four written bytes together. A sequencing fault moves the `done` pulse away from its expected cycle, or causes a write outside the four-byte field. Comparing the whole memory image against a snapshot catches stray writes, and comparing the latency against len+5 catches lost or extra cycles.

// File: rtl/cks_pkg.sv
package cks_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_DRAIN = 3'd2,
        ST_WRITE = 3'd3,
        ST_FIN   = 3'd4
    } cks_state_e;

endpackage

// File: rtl/cks_accum.sv
module cks_accum #(
    parameter int SUM_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              zero,
    input  logic [DATA_W-1:0] byte_in,
    output logic [SUM_W-1:0]  sum
);

    logic [SUM_W-1:0]  sum_d, sum_q;
    logic [DATA_W-1:0] byte_eff;

    always_comb begin
        byte_eff = zero ? '0 : byte_in;
        sum_d    = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (en) begin
            sum_d = {sum_q[SUM_W-2:0], sum_q[SUM_W-1]} + SUM_W'(byte_eff);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;

endmodule

// File: rtl/cks_field.sv
module cks_field #(
    parameter int ADDR_W = 12,
    parameter int SUM_W  = 32,
    parameter int DATA_W = 8,
    parameter int TAIL   = 9,
    localparam int LW    = ADDR_W + 1,
    localparam int NB    = SUM_W / DATA_W,
    localparam int KW    = (NB > 1) ? $clog2(NB) : 1,
    localparam int HEAD  = TAIL + NB - 1
) (
    input  logic [LW-1:0]     len,
    input  logic [LW-1:0]     idx,
    input  logic [ADDR_W-1:0] base,
    input  logic [KW-1:0]     k,
    input  logic [SUM_W-1:0]  sum,
    output logic              in_field,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_byte
);

    logic [DATA_W-1:0] lanes [NB];

    generate
        for (genvar g = 0; g < NB; g++) begin : g_lane
            assign lanes[g] = sum[SUM_W-1-g*DATA_W -: DATA_W];
        end
    endgenerate

    always_comb begin
        in_field = (idx >= (len - LW'(HEAD))) && (idx <= (len - LW'(TAIL)));
        wb_addr  = base + ADDR_W'(len - LW'(HEAD)) + ADDR_W'(k);
        wb_byte  = lanes[k];
    end

endmodule

// File: rtl/cksum_rom_gen.sv
module cksum_rom_gen
    import cks_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int TAIL   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W:0]   len_in,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [31:0]       sum_out
);

    localparam int SUM_W   = 32;
    localparam int DATA_W  = 8;
    localparam int LW      = ADDR_W + 1;
    localparam int NB      = SUM_W / DATA_W;
    localparam int KW      = (NB > 1) ? $clog2(NB) : 1;
    localparam int MIN_LEN = TAIL + NB - 1;

    typedef struct packed {
        cks_state_e        st;
        logic [ADDR_W-1:0] base;
        logic [LW-1:0]     len;
        logic [LW-1:0]     idx;
        logic              pv;
        logic [LW-1:0]     pidx;
        logic [KW-1:0]     k;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic acc_clr;
    logic in_field;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_byte;
    logic [SUM_W-1:0]  sum;

    cks_field #(
        .ADDR_W(ADDR_W), .SUM_W(SUM_W), .DATA_W(DATA_W), .TAIL(TAIL)
    ) field_i (
        .len(ctl_q.len), .idx(ctl_q.pidx), .base(ctl_q.base), .k(ctl_q.k),
        .sum(sum), .in_field(in_field), .wb_addr(wb_addr), .wb_byte(wb_byte)
    );

    cks_accum #(.SUM_W(SUM_W), .DATA_W(DATA_W)) accum_i (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(ctl_q.pv),
        .zero(in_field), .byte_in(rd_data), .sum(sum)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.pv = 1'b0;
        acc_clr  = 1'b0;
        rd_en    = 1'b0;
        wr_en    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.base = base_in;
                    ctl_d.len  = len_in;
                    ctl_d.idx  = '0;
                    ctl_d.k    = '0;
                    acc_clr    = 1'b1;
                    if (len_in < LW'(MIN_LEN)) begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_FIN;
                    end else begin
                        ctl_d.err = 1'b0;
                        ctl_d.st  = ST_READ;
                    end
                end
            end
            ST_READ: begin
                rd_en      = 1'b1;
                ctl_d.pv   = 1'b1;
                ctl_d.pidx = ctl_q.idx;
                ctl_d.idx  = ctl_q.idx + 1'b1;
                if (ctl_q.idx == ctl_q.len - 1'b1) ctl_d.st = ST_DRAIN;
            end
            ST_DRAIN: begin
                ctl_d.k  = '0;
                ctl_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                wr_en   = 1'b1;
                ctl_d.k = ctl_q.k + 1'b1;
                if (ctl_q.k == KW'(NB - 1)) ctl_d.st = ST_FIN;
            end
            ST_FIN: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_addr = ctl_q.base + ADDR_W'(ctl_q.idx);
    assign wr_addr = wb_addr;
    assign wr_data = wb_byte;
    assign busy    = (ctl_q.st != ST_IDLE);
    assign done    = (ctl_q.st == ST_FIN);
    assign err     = ctl_q.err;
    assign sum_out = sum;

    AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + ADDR_W'(1)); // R1
    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + ADDR_W'(1)); // R4
    AST_SUM_HOLD_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> $stable(sum_out)); // R4
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !rd_en && !wr_en); // R7
    AST_BUSY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(rd_addr) || rd_en); // R6

endmodule

// File: tb/cksum_rom_gen_tb.sv
module cksum_rom_gen_tb_top;

    localparam int AW   = 12;
    localparam int MSZ  = 1 << AW;
    localparam int NVEC = 8;

    typedef struct packed {
        logic [11:0] base;
        logic [12:0] len;
        logic [7:0]  seed;
        logic        rej;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{base: 12'd8,    len: 13'd4088, seed: 8'd3,   rej: 1'b0},
        '{base: 12'd0,    len: 13'd12,   seed: 8'd5,   rej: 1'b0},
        '{base: 12'd100,  len: 13'd13,   seed: 8'd9,   rej: 1'b0},
        '{base: 12'd4090, len: 13'd20,   seed: 8'd17,  rej: 1'b0},
        '{base: 12'd40,   len: 13'd11,   seed: 8'd1,   rej: 1'b1},
        '{base: 12'd200,  len: 13'd0,    seed: 8'd2,   rej: 1'b1},
        '{base: 12'd300,  len: 13'd64,   seed: 8'd255, rej: 1'b0},
        '{base: 12'd0,    len: 13'd4096, seed: 8'd77,  rej: 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] base_in = '0;
    logic [AW:0] len_in = '0;
    logic rd_en, wr_en, busy, done, err;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic [31:0] sum_out;

    logic [7:0] mem  [MSZ];
    logic [7:0] snap [MSZ];

    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    int rd_bad = 0;
    logic [AW-1:0] exp_base = '0;
    logic [AW-1:0] prev_rd = '0;

    always #10 clk = ~clk;

    cksum_rom_gen #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in),
        .len_in(len_in), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
        .done(done), .err(err), .sum_out(sum_out)
    );

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always @(posedge clk) begin
        if (rd_en) begin
            if (rd_cnt == 0) begin
                if (rd_addr != exp_base) rd_bad++;
            end else if (rd_addr != prev_rd + 1'b1) begin
                rd_bad++;
            end
            prev_rd = rd_addr;
            rd_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] seed);
        for (int a = 0; a < MSZ; a++) begin
            mem[a]  = 8'((a * seed) ^ (a >> 3) ^ seed);
            snap[a] = mem[a];
        end
    endtask

    function automatic logic [31:0] model_sum(input int b, input int l);
        logic [31:0] s = 32'd0;
        for (int i = 0; i < l; i++) begin
            logic [7:0] v = snap[(b + i) % MSZ];
            if (i >= l - 12 && i <= l - 9) v = 8'd0;
            s = {s[30:0], s[31]} + 32'(v);
        end
        return s;
    endfunction

    // inj >= 0: raise start with other values at that cycle count of the job
    task automatic run_job(input int b, input int l, input int inj, output int lat);
        @(negedge clk);
        base_in = AW'(b);
        len_in = (AW+1)'(l);
        start = 1'b1;
        rd_cnt = 0;
        rd_bad = 0;
        exp_base = AW'(b);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == inj) begin
                start = 1'b1;
                base_in = AW'(b + 1000);
                len_in = (AW+1)'(20);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
    endtask

    task automatic check_job(input int b, input int l, input bit rej, input int lat, input string tag);
        logic [31:0] es;
        int mism;
        es = rej ? 32'd0 : model_sum(b, l);
        check({tag, " R2 R3 R5 sum_out"}, sum_out, es);
        check({tag, " R7 err"}, 32'(err), 32'(rej));
        check({tag, " R5 latency"}, 32'(lat), rej ? 32'd0 : 32'(l + 5));
        check({tag, " R1 read count"}, 32'(rd_cnt), rej ? 32'd0 : 32'(l));
        check({tag, " R1 R8 read order"}, 32'(rd_bad), 32'd0);
        mism = 0;
        for (int a = 0; a < MSZ; a++) begin
            logic [7:0] ev = snap[a];
            if (!rej) begin
                for (int k = 0; k < 4; k++)
                    if (a == (b + l - 12 + k) % MSZ) ev = es[31-8*k -: 8];
            end
            if (mem[a] !== ev) mism++;
        end
        check({tag, " R4 R8 memory image"}, 32'(mism), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R5 done one cycle"}, 32'(done), 32'd0);
        check({tag, " R5 idle after"}, 32'(busy), 32'd0);
        check({tag, " R5 sum held"}, sum_out, es);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        fill(8'd1);
        repeat (3) @(negedge clk);
        check("R9 busy", 32'(busy), 32'd0);
        check("R9 done", 32'(done), 32'd0);
        check("R9 err", 32'(err), 32'd0);
        check("R9 strobes", 32'({rd_en, wr_en}), 32'd0);
        check("R9 sum_out", sum_out, 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            fill(VECS[v].seed);
            run_job(int'(VECS[v].base), int'(VECS[v].len), -1, lat);
            check_job(int'(VECS[v].base), int'(VECS[v].len), VECS[v].rej, lat, $sformatf("vec%0d", v));
        end

        // R6: start with other values while busy has no effect
        fill(8'd33);
        run_job(500, 30, 10, lat);
        check_job(500, 30, 1'b0, lat, "r6_busy_start");
        fill(8'd34);
        run_job(600, 12, 16, lat);
        check_job(600, 12, 1'b0, lat, "r6_start_in_write");

        // R3: field bytes forced to 0xFF give the same sum as any other content
        fill(8'd50);
        for (int k = 0; k < 4; k++) begin
            mem[700 + 40 - 12 + k] = 8'hFF;
            snap[700 + 40 - 12 + k] = 8'hFF;
        end
        run_job(700, 40, -1, lat);
        check_job(700, 40, 1'b0, lat, "r3_field_ff");

        // R7: refusal after a good job clears sum, then a good job clears err
        fill(8'd60);
        run_job(10, 5, -1, lat);
        check_job(10, 5, 1'b1, lat, "r7_after_good");
        run_job(10, 12, -1, lat);
        check_job(10, 12, 1'b0, lat, "r7_err_cleared");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule